// File: doc/BRIEF.md
# Set-Associative Byte Lookup Store

This block is a small set-associative cache array with two independent request channels. The lookup channel presents a set index, a tag and a byte offset. One cycle later the block answers with a response strobe, a hit flag and a 32-bit data word. On a hit, that word holds the addressed byte of the matching block in its low eight bits. On a miss, it holds the fixed marker 0xDEADBEEF. The fill channel delivers a complete block, with its tag and set index, in a single cycle. The block stores it in the first free way of the indexed set. When that set has no free way, the block writes it into way 0.

The block keeps no recency information and has no backing-memory port. A surrounding controller decides when to fill. It can treat the marker word or the cleared hit flag as the signal to fetch the block elsewhere. The number of sets, the number of ways, the bytes per block and the tag width are all parameters.

Top module: `setcache_store`

## Requirements
- R1: After reset, every way is invalid, `rspValid` and `rspHit` are low, and every lookup misses until a fill has been accepted.
- R2: A lookup accepted on a clock edge (`lkValid` high) produces `rspValid` high after that same edge, for exactly one cycle. `rspValid` is low after any edge where `lkValid` was low.
- R3: A lookup hits only when some way of the indexed set is valid and holds a tag equal to `lkTag`. A different tag, or a different set, gives a miss.
- R4: On a hit, `rspData[7:0]` is byte `k` of the stored block, that is, fill data bits `8k+7:8k`, where `k` is `lkOffset`. `rspData[31:8]` is zero.
- R5: On a miss, `rspHit` is 0 and `rspData` is 32'hDEADBEEF.
- R6: A fill writes the lowest-numbered invalid way of the indexed set.
- R7: When every way of the indexed set is valid, a fill overwrites way 0 and leaves the other ways unchanged.
- R8: A fill stores the tag and all block bytes and sets the valid bit on one edge, so a lookup issued in the following cycle hits.
- R9: When a lookup and a fill are issued in the same cycle, the lookup sees the contents as they were before the fill.
- R10: A fill changes only the set it indexes.
- R11: If several valid ways in a set hold the requested tag, the lowest-numbered of them supplies the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request strobe |
| lkIndex | input | IDX_W | Lookup set index |
| lkTag | input | TAG_W | Lookup tag |
| lkOffset | input | OFF_W | Byte offset within the block |
| fillValid | input | 1 | Fill request strobe |
| fillIndex | input | IDX_W | Fill set index |
| fillTag | input | TAG_W | Fill tag |
| fillData | input | BLOCK_BYTES*8 | Whole block; byte k sits in bits 8k+7:8k |
| rspValid | output | 1 | Response strobe, one cycle after a lookup |
| rspHit | output | 1 | Response is a hit |
| rspData | output | 32 | Zero-extended byte on a hit, 32'hDEADBEEF on a miss |

## Verification
The bench fills one set until it is full and then fills it again. This exposes a victim chooser that skips the lowest free way, or one that evicts a way other than 0 when the set is full: the wrong tag would vanish, or the evicted tag would still hit. Refilling a tag that is already stored in a higher way leaves two matching ways. This catches a hit mux that gives priority to the wrong way, which would return the stale bytes. A lookup issued in the same cycle as a fill to the same set must still miss, so a design that forwards the fill early is caught. A mid-run reset must make earlier contents unreachable, so a design that fails to clear its valid bits is caught.

// File: rtl/setcache_pkg.sv
package setcache_pkg;

  localparam logic [31:0] MISS_WORD = 32'hDEADBEEF;

  // strobes the control hands to the datapath each cycle
  typedef struct packed {
    logic doFill;
    logic doLookup;
  } cacheStrobesT;

endpackage

// File: rtl/setcache_ctrl.sv
module setcache_ctrl
  import setcache_pkg::*;
#(
  parameter int NUM_WAYS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lkValid,
  input  logic                fillValid,
  input  logic [NUM_WAYS-1:0] setValid,
  output cacheStrobesT        strobes,
  output logic [NUM_WAYS-1:0] fillWayOH
);

  logic anyFree;

  always_comb begin
    strobes.doFill   = fillValid;
    strobes.doLookup = lkValid;
  end

  // victim choice: lowest free way, else way 0
  always_comb begin
    fillWayOH = '0;
    anyFree   = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!setValid[w] && !anyFree) begin
        fillWayOH[w] = 1'b1;
        anyFree      = 1'b1;
      end
    end
    if (!anyFree) fillWayOH[0] = 1'b1;
  end

  // R6
  free_way_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.doFill && !(&setValid)) |->
      (((fillWayOH & setValid) == '0) &&
       (((fillWayOH - NUM_WAYS'(1)) & ~setValid) == '0)));

  // R7
  full_set_way0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.doFill && (&setValid)) |-> (fillWayOH == NUM_WAYS'(1)));

  // R6
  single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.doFill |-> ($countones(fillWayOH) == 1));

endmodule

// File: rtl/setcache_datapath.sv
module setcache_datapath
  import setcache_pkg::*;
#(
  parameter int NUM_SETS    = 4,
  parameter int NUM_WAYS    = 2,
  parameter int BLOCK_BYTES = 4,
  parameter int TAG_W       = 8,
  localparam int IDX_W      = $clog2(NUM_SETS),
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int BLK_W      = BLOCK_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  cacheStrobesT        strobes,
  input  logic [NUM_WAYS-1:0] fillWayOH,
  input  logic [IDX_W-1:0]    fillIndex,
  input  logic [TAG_W-1:0]    fillTag,
  input  logic [BLK_W-1:0]    fillData,
  input  logic [IDX_W-1:0]    lkIndex,
  input  logic [TAG_W-1:0]    lkTag,
  input  logic [OFF_W-1:0]    lkOffset,
  output logic [NUM_WAYS-1:0] setValid,
  output logic                rspValid,
  output logic                rspHit,
  output logic [31:0]         rspData
);

  logic [NUM_WAYS-1:0] validQ [NUM_SETS];
  logic [TAG_W-1:0]    tagQ   [NUM_SETS][NUM_WAYS];
  logic [BLK_W-1:0]    dataQ  [NUM_SETS][NUM_WAYS];

  logic [NUM_WAYS-1:0] hitVec;
  logic [BLK_W-1:0]    wayData [NUM_WAYS];
  logic [BLK_W-1:0]    selBlock;
  logic                anyHit;
  logic [7:0]          selByte;
  logic                fillSeenQ;

  assign setValid = validQ[fillIndex];

  // per-way tag compare and storage
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign hitVec[w]  = validQ[lkIndex][w] && (tagQ[lkIndex][w] == lkTag);
    assign wayData[w] = dataQ[lkIndex][w];

    always_ff @(posedge clk) begin
      if (strobes.doFill && fillWayOH[w]) begin
        tagQ[fillIndex][w]  <= fillTag;
        dataQ[fillIndex][w] <= fillData;
      end
    end
  end

  // lowest matching way wins
  always_comb begin
    selBlock = '0;
    anyHit   = 1'b0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) begin
        selBlock = wayData[w];
        anyHit   = 1'b1;
      end
    end
  end

  assign selByte = selBlock[int'(lkOffset) * 8 +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) validQ[s] <= '0;
      fillSeenQ <= 1'b0;
    end else if (strobes.doFill) begin
      validQ[fillIndex] <= validQ[fillIndex] | fillWayOH;
      fillSeenQ         <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspData  <= MISS_WORD;
    end else begin
      rspValid <= strobes.doLookup;
      if (strobes.doLookup) begin
        rspHit  <= anyHit;
        rspData <= anyHit ? {24'd0, selByte} : MISS_WORD;
      end
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.doLookup |=> rspValid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.doLookup |=> !rspValid);

  // R5
  miss_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && !rspHit) |-> (rspData == MISS_WORD));

  // R4
  hit_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspHit) |-> (rspData[31:8] == 24'd0));

  // R1
  no_hit_before_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspHit |-> fillSeenQ);

endmodule

// File: rtl/setcache_store.sv
module setcache_store
  import setcache_pkg::*;
#(
  parameter int NUM_SETS    = 4,
  parameter int NUM_WAYS    = 2,
  parameter int BLOCK_BYTES = 4,
  parameter int TAG_W       = 8,
  localparam int IDX_W      = $clog2(NUM_SETS),
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int BLK_W      = BLOCK_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lkValid,
  input  logic [IDX_W-1:0] lkIndex,
  input  logic [TAG_W-1:0] lkTag,
  input  logic [OFF_W-1:0] lkOffset,
  input  logic             fillValid,
  input  logic [IDX_W-1:0] fillIndex,
  input  logic [TAG_W-1:0] fillTag,
  input  logic [BLK_W-1:0] fillData,
  output logic             rspValid,
  output logic             rspHit,
  output logic [31:0]      rspData
);

  cacheStrobesT        strobes;
  logic [NUM_WAYS-1:0] fillWayOH;
  logic [NUM_WAYS-1:0] setValid;

  setcache_ctrl #(.NUM_WAYS(NUM_WAYS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkValid   (lkValid),
    .fillValid (fillValid),
    .setValid  (setValid),
    .strobes   (strobes),
    .fillWayOH (fillWayOH)
  );

  setcache_datapath #(
    .NUM_SETS    (NUM_SETS),
    .NUM_WAYS    (NUM_WAYS),
    .BLOCK_BYTES (BLOCK_BYTES),
    .TAG_W       (TAG_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .fillWayOH (fillWayOH),
    .fillIndex (fillIndex),
    .fillTag   (fillTag),
    .fillData  (fillData),
    .lkIndex   (lkIndex),
    .lkTag     (lkTag),
    .lkOffset  (lkOffset),
    .setValid  (setValid),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspData   (rspData)
  );

endmodule

// File: tb/setcache_store_test.sv
`timescale 1ns/1ps
module setcache_store_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkValid = 1'b0;
  logic [1:0]  lkIndex = '0;
  logic [7:0]  lkTag = '0;
  logic [1:0]  lkOffset = '0;
  logic        fillValid = 1'b0;
  logic [1:0]  fillIndex = '0;
  logic [7:0]  fillTag = '0;
  logic [31:0] fillData = '0;
  logic        rspValid, rspHit;
  logic [31:0] rspData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  setcache_store uut (
    .clk(clk), .rst_n(rst_n),
    .lkValid(lkValid), .lkIndex(lkIndex), .lkTag(lkTag), .lkOffset(lkOffset),
    .fillValid(fillValid), .fillIndex(fillIndex), .fillTag(fillTag), .fillData(fillData),
    .rspValid(rspValid), .rspHit(rspHit), .rspData(rspData)
  );

  typedef struct packed {
    logic        isFill;
    logic [1:0]  idx;
    logic [7:0]  tag;
    logic [1:0]  off;
    logic [31:0] data;
    logic        expHit;
    logic [7:0]  expByte;
    logic [3:0]  req;
  } vecT;

  localparam int NVEC = 18;
  localparam logic [57:0] VECS [NVEC] = '{
    {1'b0, 2'd0, 8'h11, 2'd0, 32'h0,        1'b0, 8'h00, 4'd1},  // R1 empty
    {1'b1, 2'd0, 8'h11, 2'd0, 32'h44332211, 1'b0, 8'h00, 4'd8},
    {1'b0, 2'd0, 8'h11, 2'd0, 32'h0,        1'b1, 8'h11, 4'd8},  // R8
    {1'b0, 2'd0, 8'h11, 2'd3, 32'h0,        1'b1, 8'h44, 4'd4},  // R4
    {1'b0, 2'd0, 8'h12, 2'd0, 32'h0,        1'b0, 8'h00, 4'd3},  // R3
    {1'b0, 2'd1, 8'h11, 2'd0, 32'h0,        1'b0, 8'h00, 4'd10}, // R10
    {1'b1, 2'd0, 8'h12, 2'd0, 32'h88776655, 1'b0, 8'h00, 4'd6},
    {1'b0, 2'd0, 8'h12, 2'd2, 32'h0,        1'b1, 8'h77, 4'd6},  // R6
    {1'b0, 2'd0, 8'h11, 2'd1, 32'h0,        1'b1, 8'h22, 4'd6},
    {1'b1, 2'd0, 8'h13, 2'd0, 32'hCCBBAA99, 1'b0, 8'h00, 4'd7},
    {1'b0, 2'd0, 8'h11, 2'd0, 32'h0,        1'b0, 8'h00, 4'd7},  // R7 way0 evicted
    {1'b0, 2'd0, 8'h12, 2'd0, 32'h0,        1'b1, 8'h55, 4'd7},  // R7 way1 kept
    {1'b0, 2'd0, 8'h13, 2'd3, 32'h0,        1'b1, 8'hCC, 4'd7},
    {1'b1, 2'd3, 8'h13, 2'd0, 32'hF0E0D0C0, 1'b0, 8'h00, 4'd10},
    {1'b0, 2'd3, 8'h13, 2'd1, 32'h0,        1'b1, 8'hD0, 4'd10},
    {1'b1, 2'd0, 8'h12, 2'd0, 32'h0A0B0C0D, 1'b0, 8'h00, 4'd11},
    {1'b0, 2'd0, 8'h12, 2'd0, 32'h0,        1'b1, 8'h0D, 4'd11}, // R11
    {1'b0, 2'd0, 8'h13, 2'd0, 32'h0,        1'b0, 8'h00, 4'd7}
  };

  task automatic check(input bit ok, input string reqName, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", reqName, act, exp);
    end
  endtask

  task automatic doFill(input logic [1:0] idx, input logic [7:0] tag, input logic [31:0] data);
    @(negedge clk);
    fillValid = 1'b1; fillIndex = idx; fillTag = tag; fillData = data;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  // issue a lookup and return with the response visible
  task automatic doLookup(input logic [1:0] idx, input logic [7:0] tag, input logic [1:0] off);
    @(negedge clk);
    lkValid = 1'b1; lkIndex = idx; lkTag = tag; lkOffset = off;
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  task automatic expectRsp(input bit expHit, input logic [7:0] expByte, input string reqName);
    logic [31:0] expWord;
    expWord = expHit ? {24'd0, expByte} : 32'hDEADBEEF;
    check(rspValid == 1'b1, {reqName, " rspValid"}, {31'd0, rspValid}, 32'd1);
    check(rspHit == expHit, {reqName, " rspHit"}, {31'd0, rspHit}, {31'd0, expHit});
    check(rspData == expWord, {reqName, " rspData"}, rspData, expWord);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vecT v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rspValid == 1'b0, "R1 reset rspValid", {31'd0, rspValid}, 32'd0);
    check(rspHit == 1'b0, "R1 reset rspHit", {31'd0, rspHit}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      v = vecT'(VECS[i]);
      if (v.isFill) doFill(v.idx, v.tag, v.data);
      else begin
        doLookup(v.idx, v.tag, v.off);
        expectRsp(v.expHit, v.expByte, $sformatf("R%0d vec%0d", v.req, i));
      end
    end

    // R2: response only for one cycle
    doLookup(2'd3, 8'h13, 2'd2);
    expectRsp(1'b1, 8'hE0, "R2 lookup");
    @(negedge clk);
    check(rspValid == 1'b0, "R2 idle", {31'd0, rspValid}, 32'd0);

    // R4: every offset of set 3
    for (int k = 0; k < 4; k++) begin
      logic [31:0] blk;
      blk = 32'hF0E0D0C0;
      doLookup(2'd3, 8'h13, 2'(k));
      expectRsp(1'b1, blk[k*8 +: 8], "R4 offset");
    end

    // R9: fill and lookup to the same set in one cycle
    @(negedge clk);
    fillValid = 1'b1; fillIndex = 2'd2; fillTag = 8'h21; fillData = 32'h5A6B7C8D;
    lkValid = 1'b1; lkIndex = 2'd2; lkTag = 8'h21; lkOffset = 2'd0;
    @(negedge clk);
    fillValid = 1'b0; lkValid = 1'b0;
    expectRsp(1'b0, 8'h00, "R9 same-cycle");
    doLookup(2'd2, 8'h21, 2'd0);
    expectRsp(1'b1, 8'h8D, "R9 after");

    // R1: reset again hides all contents
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    doLookup(2'd3, 8'h13, 2'd0);
    expectRsp(1'b0, 8'h00, "R1 post-reset");
    doLookup(2'd0, 8'h12, 2'd0);
    expectRsp(1'b0, 8'h00, "R1 post-reset");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule